// File: doc/BRIEF.md
# Double-Buffered Register Update Controller

This block keeps a set of configuration words in two copies. A host writes the staging copy one word at a time through an address, data and write-enable port. The active copy feeds the downstream datapath and changes only when an update request is seen. When the request is seen, every staging word moves into the active copy in the same clock edge. A host can therefore rebuild a whole configuration piece by piece without the datapath ever running on a mix of old and new settings.

Update requests are sampled on a slow synchronization clock. That clock is the system clock divided by a parameter (four by default) and is also driven out of the block, so that external logic can line its requests up with it. The request may come from another clock domain. It passes through a two-stage synchronizer that advances only on the rising edges of the divided clock. A request that is set up before a divided-clock rising edge therefore always produces its transfer after the same number of cycles. A request that is not set up can arrive one divided period later. A one-cycle flag marks the cycle in which the new active values appear.

Top module: `supd_top`

## Requirements
- R1: `sync_clk_o` has a period of SYNC_DIV system clocks. It is high for the first SYNC_DIV/2 of them. It is high while reset is held and during the cycle after reset is released. Its first rising edge comes at the SYNC_DIV-th system clock edge after reset is released, and every SYNC_DIV-th edge after that.
- R2: While reset is held, and just after it is released, both the staging word and the active word at index i hold the low DATA_W bits of (i+1) × 0x1111111111111111, and `upd_done` is 0.
- R3: Writes to the staging words never change `act_regs` until a transfer occurs.
- R4: `upd_req` is sampled only at the system clock edges where `sync_clk_o` rises. A request that is high only between two such edges is ignored.
- R5: If `upd_req` was sampled low at one sync rising edge and high at the next, the transfer happens at the following sync rising edge, SYNC_DIV system clocks later. A request raised just after a sync rising edge therefore shows new active values exactly 2 × SYNC_DIV system clocks later.
- R6: A transfer copies all NUM_REGS staging words into the active words in one edge. A staging write that lands on the transfer edge reaches only the staging copy, and the active copy takes the earlier staging value.
- R7: A request held high across many sync edges causes exactly one transfer. Another transfer needs the request to be sampled low and then high again.
- R8: `upd_done` is high for exactly one system clock: the cycle in which the new active values first appear. It is low at all other times.
- R9: Staging words can be written in any order. The value transferred for each index is the last one written to it before the transfer edge. The word at index a occupies bits [a×DATA_W +: DATA_W] of `act_regs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stg_we | input | 1 | Staging write enable |
| stg_addr | input | ADDR_W | Staging word index |
| stg_wdata | input | DATA_W | Staging write data |
| upd_req | input | 1 | Update request, may be asynchronous |
| sync_clk_o | output | 1 | Divided synchronization clock |
| act_regs | output | NUM_REGS×DATA_W | Active words, word i at bits [i×DATA_W +: DATA_W] |
| upd_done | output | 1 | One-cycle flag marking the cycle new active values appear |

## Verification
The bench builds the block with NUM_REGS=4, DATA_W=16 and SYNC_DIV=4. The flattened active output is then 64 bits wide, and every staging index can be written, overwritten and transferred many times within a few thousand cycles. With a divide of four, a sync period holds three non-sampling edges, so short requests can be placed between sampling edges and the exact 2 × SYNC_DIV latency can be measured. The 16-bit word width keeps the reset patterns distinct from one index to the next. Under random writes and requests that change at arbitrary times, the reference model follows every edge.

// File: rtl/supd_pkg.sv
package supd_pkg;

  // Widest word the reset pattern generator supports.
  localparam int unsigned MAX_WORD_W = 64;

  // Reset pattern of word idx; callers keep the low bits they need.
  function automatic logic [MAX_WORD_W-1:0] reset_word(input int unsigned idx);
    logic [MAX_WORD_W-1:0] base;
    base = MAX_WORD_W'(idx) + MAX_WORD_W'(1);
    return base * 64'h1111_1111_1111_1111;
  endfunction

endpackage

// File: rtl/supd_sync_div.sv
// Divided synchronization clock, produced as a registered level plus an
// enable that marks the system clock edge on which that level rises.
module supd_sync_div #(
  parameter int unsigned SYNC_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic sync_clk_o,
  output logic rise_en
);
  localparam int unsigned CNT_W = (SYNC_DIV > 2) ? $clog2(SYNC_DIV) : 1;
  localparam int unsigned HALF  = SYNC_DIV / 2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYNC_DIV - 1);

  logic [CNT_W-1:0] phase_q;
  logic [CNT_W-1:0] phase_nxt;
  logic             level_nxt;

  always_comb begin
    phase_nxt = (phase_q == LAST) ? '0 : phase_q + CNT_W'(1);
    level_nxt = (32'(phase_nxt) < HALF);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= '0;
      sync_clk_o <= 1'b1;
    end else begin
      phase_q    <= phase_nxt;
      sync_clk_o <= level_nxt;
    end
  end

  // The next edge wraps the phase to zero, which is where the level rises.
  assign rise_en = (phase_q == LAST);

endmodule

// File: rtl/supd_req_sync.sv
// Synchronizer chain for the update request, stepped only on sync rising
// edges, with rising-edge detection on the last stage.
module supd_req_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic step_en,
  input  logic req_async,
  output logic fire
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else if (step_en) begin
      chain_q <= {chain_q[STAGES-2:0], req_async};
    end
  end

  // Fires on the step where the last stage turns from low to high.
  assign fire = step_en && chain_q[STAGES-2] && !chain_q[STAGES-1];

endmodule

// File: rtl/supd_stage_bank.sv
// Staging words written one at a time from the host side.
module supd_stage_bank #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_REGS*DATA_W-1:0] stage_flat
);
  import supd_pkg::*;

  logic [DATA_W-1:0] word_q [NUM_REGS];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_word
    localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(reset_word(gi));
    logic hit;
    assign hit = we && (addr == ADDR_W'(gi));

    always_ff @(posedge clk) begin
      if (rst) begin
        word_q[gi] <= RST_VAL;
      end else if (hit) begin
        word_q[gi] <= wdata;
      end
    end

    assign stage_flat[gi*DATA_W +: DATA_W] = word_q[gi];
  end

endmodule

// File: rtl/supd_active_bank.sv
// Active words loaded all together from the staging words.
module supd_active_bank #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic [NUM_REGS*DATA_W-1:0] stage_flat,
  output logic [NUM_REGS*DATA_W-1:0] active_flat,
  output logic                       loaded
);
  import supd_pkg::*;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_word
    localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(reset_word(gi));

    always_ff @(posedge clk) begin
      if (rst) begin
        active_flat[gi*DATA_W +: DATA_W] <= RST_VAL;
      end else if (load) begin
        active_flat[gi*DATA_W +: DATA_W] <= stage_flat[gi*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded <= 1'b0;
    end else begin
      loaded <= load;
    end
  end

endmodule

// File: rtl/supd_top.sv
module supd_top #(
  parameter int unsigned NUM_REGS    = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_DIV    = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int unsigned FLAT_W     = NUM_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stg_we,
  input  logic [ADDR_W-1:0] stg_addr,
  input  logic [DATA_W-1:0] stg_wdata,
  input  logic              upd_req,
  output logic              sync_clk_o,
  output logic [FLAT_W-1:0] act_regs,
  output logic              upd_done
);
  logic              rise_en;
  logic              xfer;
  logic [FLAT_W-1:0] stage_flat;

  supd_sync_div #(
    .SYNC_DIV(SYNC_DIV)
  ) u_div (
    .clk       (clk),
    .rst       (rst),
    .sync_clk_o(sync_clk_o),
    .rise_en   (rise_en)
  );

  supd_req_sync #(
    .STAGES(SYNC_STAGES)
  ) u_req (
    .clk      (clk),
    .rst      (rst),
    .step_en  (rise_en),
    .req_async(upd_req),
    .fire     (xfer)
  );

  supd_stage_bank #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) u_stage (
    .clk       (clk),
    .rst       (rst),
    .we        (stg_we),
    .addr      (stg_addr),
    .wdata     (stg_wdata),
    .stage_flat(stage_flat)
  );

  supd_active_bank #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W)
  ) u_active (
    .clk        (clk),
    .rst        (rst),
    .load       (xfer),
    .stage_flat (stage_flat),
    .active_flat(act_regs),
    .loaded     (upd_done)
  );

endmodule

// File: rtl/supd_checker.sv
module supd_checker #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SYNC_DIV = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       sync_clk_o,
  input logic [NUM_REGS*DATA_W-1:0] act_regs,
  input logic                       upd_done
);
  import supd_pkg::*;

  logic [NUM_REGS*DATA_W-1:0] def_flat;
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      def_flat[i*DATA_W +: DATA_W] = DATA_W'(reset_word(i));
    end
  end

  // Cycles since the last observed rise of the sync clock.
  logic sck_prev;
  int   since_rise;
  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev   <= 1'b1;
      since_rise <= 0;
    end else begin
      sck_prev   <= sync_clk_o;
      since_rise <= (sync_clk_o && !sck_prev) ? 1 : since_rise + 1;
    end
  end

  // R1: rises are exactly SYNC_DIV system clocks apart
  a_r1_sync_period: assert property (@(posedge clk) disable iff (rst)
    (sync_clk_o && !sck_prev) |-> (since_rise == SYNC_DIV));

  // R2: reset values on the active words after reset is released
  a_r2_reset_defaults: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (act_regs == def_flat));

  // R3: active words hold unless a transfer is flagged
  a_r3_hold_active: assert property (@(posedge clk) disable iff (rst)
    !upd_done |-> (act_regs == $past(act_regs)));

  // R5: transfers land only on sync rising edges
  a_r5_on_sync_edge: assert property (@(posedge clk) disable iff (rst)
    upd_done |-> (sync_clk_o && !$past(sync_clk_o)));

  // R8: the flag lasts one system clock
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    upd_done |=> !upd_done);

endmodule

bind supd_top supd_checker #(
  .NUM_REGS(NUM_REGS),
  .DATA_W  (DATA_W),
  .SYNC_DIV(SYNC_DIV)
) u_supd_checker (
  .clk       (clk),
  .rst       (rst),
  .sync_clk_o(sync_clk_o),
  .act_regs  (act_regs),
  .upd_done  (upd_done)
);

// File: tb/test_supd_top.sv
module test_supd_top;
  localparam int CLK_P  = 10;
  localparam int NR     = 4;
  localparam int DW     = 16;
  localparam int DIV    = 4;
  localparam int AW     = 2;
  localparam int FW     = NR * DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stg_we = 1'b0;
  logic [AW-1:0] stg_addr = '0;
  logic [DW-1:0] stg_wdata = '0;
  logic          upd_req = 1'b0;
  logic          sync_clk_o;
  logic [FW-1:0] act_regs;
  logic          upd_done;

  int errors = 0;
  int checks = 0;
  int done_cnt = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  supd_top #(.NUM_REGS(NR), .DATA_W(DW), .SYNC_DIV(DIV)) i_supd_top (
    .clk(clk), .rst(rst), .stg_we(stg_we), .stg_addr(stg_addr),
    .stg_wdata(stg_wdata), .upd_req(upd_req), .sync_clk_o(sync_clk_o),
    .act_regs(act_regs), .upd_done(upd_done)
  );

  function automatic logic [DW-1:0] defv(input int i);
    logic [63:0] v;
    v = 64'(i + 1) * 64'h1111_1111_1111_1111;
    return v[DW-1:0];
  endfunction

  // Behavioural reference model
  logic [DW-1:0] stage_m [NR];
  logic [DW-1:0] act_m   [NR];
  int  edges_m;
  bit  sck_m, done_m;
  bit  samples_m [$];

  function automatic logic [FW-1:0] flat_m();
    logic [FW-1:0] f;
    for (int i = 0; i < NR; i++) f[i*DW +: DW] = act_m[i];
    return f;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NR; i++) begin stage_m[i] = defv(i); act_m[i] = defv(i); end
      edges_m = 0; sck_m = 1'b1; done_m = 1'b0;
      samples_m = {1'b0, 1'b0};
    end else begin
      edges_m++;
      done_m = 1'b0;
      if (edges_m % DIV == 0) begin
        // transfer when the request was sampled low, then high
        if (samples_m[$] && !samples_m[$-1]) begin
          for (int i = 0; i < NR; i++) act_m[i] = stage_m[i];
          done_m = 1'b1;
        end
        samples_m.push_back(upd_req);
        void'(samples_m.pop_front());
      end
      if (stg_we) stage_m[int'(stg_addr)] = stg_wdata;
      sck_m = ((edges_m % DIV) < DIV/2);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [FW-1:0] got,
                     input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(sync_clk_o == sck_m, "R1 sync clock level", FW'(sync_clk_o), FW'(sck_m));
      chk(upd_done == done_m, "R8 done flag", FW'(upd_done), FW'(done_m));
      chk(act_regs == flat_m(), "R6 active words", act_regs, flat_m());
      if (upd_done) done_cnt++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    stg_we = 1'b1; stg_addr = AW'(a); stg_wdata = d;
    @(negedge clk);
    stg_we = 1'b0;
  endtask

  task automatic wait_rise();
    logic p;
    do begin p = sync_clk_o; @(negedge clk); end while (!(sync_clk_o && !p));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin : stim
    logic [FW-1:0] exp_f;
    logic [FW-1:0] snap;
    int lat, d0;
    cyc(3);
    // R2: reset state
    for (int i = 0; i < NR; i++) exp_f[i*DW +: DW] = defv(i);
    chk(act_regs == exp_f, "R2 reset active words", act_regs, exp_f);
    chk(upd_done == 1'b0, "R2 reset done flag", FW'(upd_done), '0);
    chk(sync_clk_o == 1'b1, "R1 reset sync level", FW'(sync_clk_o), FW'(1));
    rst = 1'b0;
    @(negedge clk);
    chk(act_regs == exp_f, "R2 defaults after reset", act_regs, exp_f);

    // R3 and R9: out-of-order writes, overwrite, no effect yet
    wr(2, 16'hAAAA); wr(0, 16'h1234); wr(2, 16'hBEEF); wr(3, 16'h0F0F); wr(1, 16'h5555);
    cyc(3 * DIV);
    chk(act_regs == exp_f, "R3 writes without update", act_regs, exp_f);

    // R5: exact latency from a request raised just after a sync rise
    wait_rise();
    upd_req = 1'b1;
    lat = 0; d0 = done_cnt;
    while (!upd_done && lat < 4 * DIV) begin @(negedge clk); lat++; end
    chk(lat == 2 * DIV, "R5 aligned latency", FW'(lat), FW'(2 * DIV));
    exp_f = {16'h0F0F, 16'hBEEF, 16'h5555, 16'h1234};
    chk(act_regs == exp_f, "R9 last write wins", act_regs, exp_f);

    // R7: hold high for many sync periods, exactly one transfer
    cyc(10 * DIV);
    chk(done_cnt - d0 == 1, "R7 single transfer on long request", FW'(done_cnt - d0), FW'(1));
    upd_req = 1'b0;
    cyc(3 * DIV);

    // R4: one-cycle pulse between sync edges is ignored
    wr(1, 16'h7777);
    wait_rise();
    d0 = done_cnt; snap = act_regs;
    upd_req = 1'b1; @(negedge clk); upd_req = 1'b0;
    cyc(4 * DIV);
    chk(done_cnt == d0, "R4 short request ignored", FW'(done_cnt - d0), '0);
    chk(act_regs == snap, "R4 active words unchanged", act_regs, snap);

    // R6: write landing on the transfer edge goes to staging only
    wait_rise();
    upd_req = 1'b1;
    cyc(2 * DIV - 1);
    stg_we = 1'b1; stg_addr = 2'd0; stg_wdata = 16'hC0DE;
    @(negedge clk);
    stg_we = 1'b0;
    exp_f = {16'h0F0F, 16'hBEEF, 16'h7777, 16'h1234};
    chk(upd_done == 1'b1, "R6 transfer cycle", FW'(upd_done), FW'(1));
    chk(act_regs == exp_f, "R6 same-edge write excluded", act_regs, exp_f);
    upd_req = 1'b0;
    cyc(3 * DIV);
    upd_req = 1'b1;
    cyc(4 * DIV);
    upd_req = 1'b0;
    exp_f[DW-1:0] = 16'hC0DE;
    chk(act_regs == exp_f, "R6 staged value arrives next transfer", act_regs, exp_f);

    // Random writes and requests at arbitrary sub-cycle times
    for (int n = 0; n < 4000; n++) begin
      stg_we = ($urandom % 3) == 0;
      stg_addr = AW'($urandom);
      stg_wdata = DW'($urandom);
      if (($urandom % 5) == 0) begin
        #(1 + $urandom % 3);
        upd_req = ~upd_req;
      end
      @(negedge clk);
    end
    stg_we = 1'b0; upd_req = 1'b0;
    cyc(4 * DIV);

    // R2: reset again mid-run
    rst = 1'b1; cyc(2); rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NR; i++) exp_f[i*DW +: DW] = defv(i);
    chk(act_regs == exp_f, "R2 defaults after second reset", act_regs, exp_f);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule